// File: doc/BRIEF.md
# SPI Master with Hardware Slave-Select Pulsing

This block is a serial peripheral interface master for one slave. It shifts out frames of 4 to 16 bits, most significant bit first, and captures the slave's reply from MISO into a receive word. A baud field sets the SCK rate. The clock polarity and the clock phase are both selectable.

The block drives the slave-select line NSS itself. A one-word holding register lets software queue the next word while the current frame is still shifting. When the queued word arrives in time, frames run back to back. With pulse mode on and phase 0 selected, NSS rises for one SCK period between consecutive frames. With pulse mode off, or with phase 1 selected, NSS stays low across the whole run. At the end of a run NSS always returns high.

The controller is an engine with five states:
- `ST_IDLE`: NSS is high. The engine goes to `ST_SETUP` when the holding register is occupied.
- `ST_SETUP`: NSS is low for half an SCK period. The engine then goes to `ST_XFER`.
- `ST_XFER`: the engine runs 2N SCK edges. After the last edge it goes to one of three states:
  - back to `ST_XFER`, when a word is queued and no pulse is due;
  - `ST_GAP`, when a word is queued and a pulse is due;
  - `ST_TAIL`, when nothing is queued.
- `ST_GAP`: NSS is high for two half periods. The engine then goes to `ST_SETUP`.
- `ST_TAIL`: NSS is still low for a final half period. The engine then goes to `ST_IDLE`.

Clearing the enable bit forces `ST_IDLE` from any state.

Top module: `spi_nss_master`

## Requirements
- R1: The baud field (config bits 5:3) sets each SCK half period to 2^code system clocks. The SCK period is therefore the system clock divided by 2, 4, 8 and so on up to 256, for codes 0 to 7.
- R2: The size field (config bits 9:6) holding code c gives frames of c+1 bits, for c from 3 to 15. MOSI sends each frame most significant bit first.
- R3: A size code of 0, 1 or 2 is stored as 7 (8-bit frames). After reset the stored size code is 7 and every other config bit is 0, so the readback is 0x1C0.
- R4: When NSS is high, SCK sits at the idle level given by the polarity bit (config bit 1): 0 means idle low and 1 means idle high.
- R5: Phase bit 0 (config bit 2) captures data on the odd SCK edges of a frame and launches it on the even edges. The first bit is already on MOSI before edge 1. Phase bit 1 launches on the odd edges and captures on the even edges.
- R6: Pulse mode applies when the pulse bit (config bit 10) is 1 and the phase bit is 0. In that case NSS goes high between two consecutive frames for at least one SCK period. Before the first edge of every frame, NSS has been low for at least half an SCK period.
- R7: With the phase bit at 1, the pulse bit has no effect, and NSS stays low between consecutive frames.
- R8: A word accepted before the current frame's last SCK edge follows that frame without a gap in NSS when pulse mode does not apply. When no word is queued, NSS returns high after the frame.
- R9: The NSS output enable is high only when both the enable bit (config bit 0) and the slave-select drive bit (config bit 11) are 1. Otherwise the NSS pin is undriven.
- R10: A config write updates the pulse bit only while the stored enable bit is 0. A write made while the block is enabled leaves the pulse bit unchanged.
- R11: The receive-valid output pulses for exactly one clock at the end of each frame. The receive data then holds the N bits captured from MISO, most significant bit first, with zeros above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_wdata | input | 12 | Config word to write |
| cfg_rdata | output | 12 | Stored config word |
| tx_data | input | 16 | Transmit word, right-aligned |
| tx_valid | input | 1 | Transmit word valid |
| tx_ready | output | 1 | Holding register free and block enabled |
| rx_data | output | 16 | Received word, right-aligned |
| rx_valid | output | 1 | One-clock strobe when a frame completes |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| nss_o | output | 1 | Slave-select level |
| nss_oe | output | 1 | Slave-select output enable (0 means the pin is undriven) |

## Verification
The hardest situation to reach from the ports is a run of frames that truly follow each other. The next word must already sit in the holding register when the last SCK edge of the current frame occurs, because that edge alone decides whether the engine reloads, pulses NSS or ends the run. The stimulus therefore presents each following word as soon as the ready output rises, so the register refills within the first frame.

The bench drives this run under every pairing of phase and pulse mode. It counts NSS rises between frames, measures how long each pulse lasts, and checks that a pulse-mode bit written while the block is enabled leaves the NSS behaviour of a later run unchanged.

// File: rtl/spi_nss_pkg.sv
package spi_nss_pkg;

    localparam int DATA_W = 16;
    localparam int DSZ_W  = 4;
    localparam int BAUD_W = 3;
    localparam int EDGE_W = $clog2(2 * DATA_W + 1);

    localparam logic [DSZ_W-1:0] DSZ_MIN      = DSZ_W'(3);
    localparam logic [DSZ_W-1:0] DSZ_FALLBACK = DSZ_W'(7);

    typedef struct packed {
        logic             ss_drive;
        logic             gap_pulse;
        logic [DSZ_W-1:0] size_code;
        logic [BAUD_W-1:0] rate;
        logic             late_phase;
        logic             idle_high;
        logic             run;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    localparam cfg_t CFG_RESET = '{
        ss_drive:   1'b0,
        gap_pulse:  1'b0,
        size_code:  DSZ_FALLBACK,
        rate:       '0,
        late_phase: 1'b0,
        idle_high:  1'b0,
        run:        1'b0
    };

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_XFER,
        ST_GAP,
        ST_TAIL
    } eng_state_t;

    function automatic logic [DSZ_W-1:0] legal_size(input logic [DSZ_W-1:0] code);
        return (code < DSZ_MIN) ? DSZ_FALLBACK : code;
    endfunction

endpackage

// File: rtl/spi_nss_cfg.sv
module spi_nss_cfg
    import spi_nss_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg
);

    cfg_t req;
    assign req = cfg_t'(wdata);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= CFG_RESET;
        end else if (wr) begin
            cfg.run        <= req.run;
            cfg.idle_high  <= req.idle_high;
            cfg.late_phase <= req.late_phase;
            cfg.rate       <= req.rate;
            cfg.size_code  <= legal_size(req.size_code);
            cfg.ss_drive   <= req.ss_drive;
            if (!cfg.run) begin
                cfg.gap_pulse <= req.gap_pulse;
            end
        end
    end

endmodule

// File: rtl/spi_nss_baud.sv
module spi_nss_baud #(
    parameter int BAUD_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [BAUD_W-1:0] rate,
    output logic              tick
);

    localparam int CNT_W = 2 ** BAUD_W;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_m1;

    assign half_m1 = (CNT_W'(1) << rate) - CNT_W'(1);
    assign tick    = run && (cnt == half_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/spi_nss_engine.sv
module spi_nss_engine
    import spi_nss_pkg::*;
#(
    parameter int D_W = DATA_W,
    parameter int S_W = DSZ_W,
    parameter int E_W = EDGE_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           cpha,
    input  logic           pulse_en,
    input  logic [S_W-1:0] size_code,
    input  logic           tick,
    input  logic [D_W-1:0] tx_data,
    input  logic           tx_valid,
    output logic           tx_ready,
    input  logic           miso,
    output logic           run,
    output logic           sck_ph,
    output logic           mosi,
    output logic           nss_level,
    output logic [D_W-1:0] rx_data,
    output logic           rx_valid
);

    eng_state_t st, st_nx;

    logic [E_W-1:0] ecnt;
    logic [E_W-1:0] e_now;
    logic [E_W-1:0] last_edge;
    logic           gap_second;
    logic [D_W-1:0] tx_sh;
    logic [D_W-1:0] rx_sh;
    logic [D_W-1:0] rx_next;
    logic [D_W-1:0] hold_q;
    logic           hold_full;
    logic [D_W-1:0] mask;
    logic           is_odd;
    logic           is_last;
    logic           is_capture;
    logic           is_launch;
    logic           pulse_act;

    assign e_now      = ecnt + E_W'(1);
    assign last_edge  = (E_W'(size_code) + E_W'(1)) << 1;
    assign is_odd     = e_now[0];
    assign is_last    = (e_now == last_edge);
    assign is_capture = cpha ? !is_odd : is_odd;
    assign is_launch  = !is_last && (cpha ? (is_odd && (e_now != E_W'(1))) : !is_odd);
    assign pulse_act  = pulse_en && !cpha;
    assign rx_next    = {rx_sh[D_W-2:0], miso};

    always_comb begin
        for (int i = 0; i < D_W; i++) begin
            mask[i] = (i <= int'(size_code));
        end
    end

    // next-state decision
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (hold_full) st_nx = ST_SETUP;
            ST_SETUP: if (tick) st_nx = ST_XFER;
            ST_XFER: begin
                if (tick && is_last) begin
                    if (!hold_full)     st_nx = ST_TAIL;
                    else if (pulse_act) st_nx = ST_GAP;
                    else                st_nx = ST_XFER;
                end
            end
            ST_GAP:   if (tick && gap_second) st_nx = ST_SETUP;
            ST_TAIL:  if (tick) st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
        if (!en) st_nx = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ecnt       <= '0;
            gap_second <= 1'b0;
            tx_sh      <= '0;
            rx_sh      <= '0;
            hold_q     <= '0;
            hold_full  <= 1'b0;
            sck_ph     <= 1'b0;
            rx_data    <= '0;
            rx_valid   <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (!en) begin
                hold_full  <= 1'b0;
                sck_ph     <= 1'b0;
                ecnt       <= '0;
                gap_second <= 1'b0;
            end else begin
                if (tx_valid && tx_ready) begin
                    hold_q    <= tx_data;
                    hold_full <= 1'b1;
                end
                unique case (st)
                    ST_IDLE: begin
                        if (hold_full) begin
                            tx_sh     <= hold_q;
                            hold_full <= 1'b0;
                            ecnt      <= '0;
                            sck_ph    <= 1'b0;
                        end
                    end
                    ST_XFER: begin
                        if (tick) begin
                            sck_ph <= ~sck_ph;
                            ecnt   <= e_now;
                            if (is_capture) rx_sh <= rx_next;
                            if (is_launch)  tx_sh <= tx_sh << 1;
                            if (is_last) begin
                                rx_valid <= 1'b1;
                                rx_data  <= (is_capture ? rx_next : rx_sh) & mask;
                                ecnt     <= '0;
                                if (hold_full) begin
                                    tx_sh     <= hold_q;
                                    hold_full <= 1'b0;
                                end
                            end
                        end
                    end
                    ST_GAP: begin
                        if (tick) gap_second <= !gap_second;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        nss_level = (st == ST_IDLE) || (st == ST_GAP);
        run       = (st != ST_IDLE);
        tx_ready  = en && !hold_full;
        mosi      = tx_sh[size_code];
    end

endmodule

// File: rtl/spi_nss_master.sv
module spi_nss_master
    import spi_nss_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              nss_o,
    output logic              nss_oe
);

    cfg_t cfg;
    logic tick;
    logic run;
    logic sck_ph;
    logic nss_level;

    spi_nss_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    spi_nss_baud #(.BAUD_W(BAUD_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .rate  (cfg.rate),
        .tick  (tick)
    );

    spi_nss_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg.run),
        .cpha      (cfg.late_phase),
        .pulse_en  (cfg.gap_pulse),
        .size_code (cfg.size_code),
        .tick      (tick),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .miso      (miso),
        .run       (run),
        .sck_ph    (sck_ph),
        .mosi      (mosi),
        .nss_level (nss_level),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid)
    );

    assign cfg_rdata = cfg;
    assign sck       = cfg.idle_high ^ sck_ph;
    assign nss_o     = nss_level;
    assign nss_oe    = cfg.run && cfg.ss_drive;

endmodule

// File: rtl/spi_nss_master_chk.sv
module spi_nss_master_chk
    import spi_nss_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             nss_o,
    input logic             nss_oe,
    input logic             sck,
    input logic             rx_valid
);

    cfg_t c;
    assign c = cfg_t'(cfg_rdata);

    AST_NSS_OE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        nss_oe |-> (c.run && c.ss_drive)); // R9

    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        c.size_code >= DSZ_MIN); // R3

    AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        nss_o |-> (sck == c.idle_high)); // R4

    AST_SCK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sck) && $stable(c.idle_high)) |-> !$past(nss_o)); // R5

    AST_RXV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R11

    AST_PULSE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (c.run && $past(c.run)) |-> $stable(c.gap_pulse)); // R10

endmodule

bind spi_nss_master spi_nss_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_rdata (cfg_rdata),
    .nss_o     (nss_o),
    .nss_oe    (nss_oe),
    .sck       (sck),
    .rx_valid  (rx_valid)
);

// File: tb/spi_nss_master_test.sv
module spi_nss_master_test;
    import spi_nss_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [CFG_W-1:0]  cfg_wdata = '0;
    logic [CFG_W-1:0]  cfg_rdata;
    logic [DATA_W-1:0] tx_data = '0;
    logic              tx_valid = 1'b0;
    logic              tx_ready;
    logic [DATA_W-1:0] rx_data;
    logic              rx_valid;
    logic              sck;
    logic              mosi;
    logic              miso = 1'b0;
    logic              nss_o;
    logic              nss_oe;

    always #2 clk = ~clk;

    spi_nss_master uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .sck(sck), .mosi(mosi), .miso(miso), .nss_o(nss_o), .nss_oe(nss_oe)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // mirror of the programmed mode
    int m_cpol = 0, m_cpha = 0, m_nbits = 8, m_half = 1;
    bit m_pulse = 0;

    // monitor state
    int e_cnt = 0, fi = 0, rxi = 0, ccount = 0, hi_cnt = 0, rises = 0;
    int frames_done = 0, burst_first = 0, burst_target = 0;
    int mword = 0;
    bit prev_sck = 0, prev_nss = 1, prev_mosi = 0, prev_rxv = 0;
    int txq[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int nmask(input int n);
        return (1 << n) - 1;
    endfunction

    function automatic int sw(input int i);
        return (i * 16'h3B1D + 16'h5A96) & 16'hFFFF;
    endfunction

    function automatic bit swbit(input int i, input int b);
        return bit'((sw(i) >> b) & 1);
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // behavioural slave and protocol monitor, evaluated on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            ccount++;
            if (prev_nss && !nss_o) begin
                if (frames_done > burst_first && frames_done < burst_target)
                    chk(hi_cnt >= 2 * m_half, "R6 pulse width", hi_cnt, 2 * m_half);
                ccount = 0;
                if (m_cpha == 0) miso = swbit(fi, m_nbits - 1);
            end
            if (!prev_nss && nss_o) begin
                if (frames_done < burst_target) rises++;
                hi_cnt = 0;
            end
            if (nss_o) hi_cnt++;
            if (sck != prev_sck && !prev_nss) begin
                e_cnt++;
                if (e_cnt == 1) chk(ccount >= m_half, "R6 lead time", ccount, m_half);
                else            chk(ccount == m_half, "R1 half period", ccount, m_half);
                if ((m_cpha == 0) == (e_cnt % 2 == 1))
                    mword = (mword << 1) | int'(prev_mosi);
                if (e_cnt < 2 * m_nbits) begin
                    if (m_cpha == 0 && e_cnt % 2 == 0)
                        miso = swbit(fi, m_nbits - 1 - e_cnt / 2);
                    if (m_cpha == 1 && e_cnt % 2 == 1)
                        miso = swbit(fi, m_nbits - 1 - (e_cnt - 1) / 2);
                end else begin
                    int exp_w;
                    exp_w = (txq.size() > 0) ? txq.pop_front() : -1;
                    chk(mword == exp_w, "R2 R5 mosi frame", mword, exp_w);
                    fi++;
                    frames_done++;
                    e_cnt = 0;
                    mword = 0;
                    if (m_cpha == 0) miso = swbit(fi, m_nbits - 1);
                end
                ccount = 0;
            end
            if (rx_valid) begin
                chk(!prev_rxv, "R11 strobe width", int'(prev_rxv), 0);
                chk(int'(rx_data) == (sw(rxi) & nmask(m_nbits)), "R11 rx data",
                    int'(rx_data), sw(rxi) & nmask(m_nbits));
                rxi++;
            end
            prev_rxv  = rx_valid;
            prev_sck  = sck;
            prev_nss  = nss_o;
            prev_mosi = mosi;
        end
    end

    task automatic cfg_write(input bit en, input bit cpol, input bit cpha, input int baud,
                             input int code, input bit pulse, input bit ssoe);
        @(negedge clk);
        cfg_wdata = {ssoe, pulse, 4'(code), 3'(baud), cpha, cpol, en};
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup_mode(input bit cpol, input bit cpha, input int baud, input int code,
                              input bit pulse);
        cfg_write(0, cpol, cpha, baud, code, 0, 1);
        cfg_write(0, cpol, cpha, baud, code, pulse, 1);
        m_cpol = cpol;
        m_cpha = cpha;
        m_half = 1 << baud;
        m_nbits = (code < 3) ? 8 : code + 1;
        m_pulse = pulse && !cpha;
        cfg_write(1, cpol, cpha, baud, code, pulse, 1);
        @(negedge clk);
        chk(sck == bit'(m_cpol), "R4 idle level", int'(sck), m_cpol);
    endtask

    task automatic burst(input int n, input int seed, input string req);
        int exp_r;
        rises = 0;
        burst_first = frames_done;
        burst_target = frames_done + n;
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            int w;
            w = (seed + i * 16'h1357) & nmask(m_nbits);
            txq.push_back(w);
            tx_data = 16'(w);
            tx_valid = 1'b1;
            while (!tx_ready) @(negedge clk);
            @(negedge clk);
        end
        tx_valid = 1'b0;
        while (frames_done < burst_target) @(negedge clk);
        repeat (4 * m_half + 4) @(negedge clk);
        exp_r = m_pulse ? n - 1 : 0;
        chk(rises == exp_r, req, rises, exp_r);
        chk(nss_o == 1'b1, "R8 nss high after run", int'(nss_o), 1);
        chk(sck == bit'(m_cpol), "R4 idle level after run", int'(sck), m_cpol);
        chk(rxi == fi, "R11 one strobe per frame", rxi, fi);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(int'(cfg_rdata) == 12'h1C0, "R3 reset config", int'(cfg_rdata), 12'h1C0);
        chk(nss_oe == 1'b0, "R9 reset oe", int'(nss_oe), 0);
        chk(sck == 1'b0, "R4 reset sck", int'(sck), 0);
        chk(rx_valid == 1'b0, "R11 reset strobe", int'(rx_valid), 0);
        chk(tx_ready == 1'b0, "R8 ready while disabled", int'(tx_ready), 0);

        // R3 size code coercion
        for (int code = 0; code < 16; code += 1) begin
            if (code <= 3 || code == 15) begin
                int exp_c;
                cfg_write(0, 0, 0, 0, code, 0, 0);
                exp_c = (code < 3) ? 7 : code;
                chk(int'(cfg_rdata[9:6]) == exp_c, "R3 size coercion", int'(cfg_rdata[9:6]), exp_c);
            end
        end

        // R9 output enable gating
        cfg_write(1, 0, 0, 0, 7, 0, 0);
        chk(nss_oe == 1'b0, "R9 oe without drive bit", int'(nss_oe), 0);
        cfg_write(0, 0, 0, 0, 7, 0, 1);
        chk(nss_oe == 1'b0, "R9 oe while disabled", int'(nss_oe), 0);
        cfg_write(1, 0, 0, 0, 7, 0, 1);
        chk(nss_oe == 1'b1, "R9 oe driven", int'(nss_oe), 1);

        // R8 continuous frames with no pulse
        setup_mode(0, 0, 0, 7, 0);
        burst(3, 16'hA5, "R8 no rise between frames");

        // R6 pulses between frames, phase 0
        setup_mode(1, 0, 2, 15, 1);
        burst(3, 16'hC3E1, "R6 rise between frames");

        // R7 pulse bit ignored in phase 1
        setup_mode(0, 1, 1, 3, 1);
        burst(3, 16'h9, "R7 no rise in phase 1");

        // R5 phase 1 with idle-high clock, 12-bit frames
        setup_mode(1, 1, 3, 11, 0);
        burst(2, 16'h5A3, "R5 phase 1 run");

        // R8 single frame with illegal size code (coerced to 8 bits)
        setup_mode(0, 0, 1, 1, 1);
        burst(1, 16'h3C, "R8 single frame");

        // R10 pulse bit write while enabled is ignored
        setup_mode(0, 0, 0, 7, 0);
        cfg_write(1, 0, 0, 0, 7, 1, 1);
        chk(cfg_rdata[10] == 1'b0, "R10 pulse bit readback", int'(cfg_rdata[10]), 0);
        burst(3, 16'h71, "R10 no rise after ignored write");

        // R1 slowest rate
        setup_mode(0, 0, 7, 3, 0);
        burst(2, 16'h6, "R1 slow run");

        summary();
    end

endmodule